// File: doc/BRIEF.md
# Scratchpad Atomic Update Engine

This block sits next to one bank of an on-chip vertex-property scratchpad and performs read-modify-write updates in place. Instead of fetching a value, locking it and writing it back, a core posts an update: it writes an operand register and then an index register, and the write to the index register queues the update. The engine checks that the vertex index belongs to the range held by this bank, reads the stored property, combines it with the operand (wrap-around add or unsigned minimum), and writes the result back. No update to the same vertex can be lost, so software needs no lock.

Queued updates wait in an 8-entry FIFO. The read-combine-write pipeline drains one update per cycle. A back-to-back update to the vertex still being written takes its base value from the pending result and does not read the stale stored word. A separate non-atomic read port shares the SRAM read port with the pipeline and has priority over it. While reads are issued, updates stay queued, and once the queue fills the write port applies back-pressure. Vertex indices at or above the configured count belong to another path and raise a one-cycle error instead of being written.

Top module: `spu_atomic_engine`

## Requirements
- R1: After reset every scratchpad entry reads 0, `err_o` is low, `wr_ready` is high, the combine mode is add and the vertex count equals the scratchpad depth (64).
- R2: Register addresses on `wr_addr`: 0 = operand, 1 = vertex index (a write queues an update using the current operand), 2 = mode (bit 0: 0 add, 1 min), 3 = vertex count.
- R3: Add mode stores (old + operand) modulo 2^32.
- R4: Min mode stores the unsigned smaller of old value and operand.
- R5: The mode applied to an update is the one in force when its index write was accepted; a later mode write does not change queued updates.
- R6: The queue holds 8 updates. When it is full `wr_ready` is low and no register write is accepted until a slot frees.
- R7: An index greater than or equal to the vertex count raises `err_o` for exactly the one cycle after the write is accepted, and no entry changes.
- R8: Updates to the same vertex on consecutive cycles all take effect (no lost update).
- R9: `rd_data` holds the entry addressed by `rd_addr` in the cycle after `rd_en` is sampled high. While `rd_en` is high, no queued update is started.
- R10: A vertex-count write larger than the depth is clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Non-atomic read request |
| rd_addr | input | 6 | Entry to read |
| rd_data | output | 32 | Read result, one cycle after `rd_en` |
| err_o | output | 1 | Out-of-range index pulse |

## Verification
An index write accepted at edge k, with no reads pending, is popped at edge k+1 and written to the SRAM at edge k+2. A read sampled at edge k+3 or later therefore returns the new value, so the bench lets the queue drain for several cycles before issuing reads. Read data is compared in the falling-edge half of the cycle after `rd_en` was sampled, through a queue of expected values. The error pulse is sampled in the low phase that follows the accepting edge, and again one cycle later to confirm it has dropped. Back-pressure is checked on the falling edge after the eighth queued update, and again while the ninth write is held pending.

// File: rtl/spu_pkg.sv
package spu_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MIN = 1'b1
    } spu_op_e;

    localparam logic [1:0] REG_OPND  = 2'd0;
    localparam logic [1:0] REG_INDEX = 2'd1;
    localparam logic [1:0] REG_MODE  = 2'd2;
    localparam logic [1:0] REG_LIMIT = 2'd3;
endpackage

// File: rtl/spu_cfg_regs.sv
module spu_cfg_regs
    import spu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_full,
    output logic          wr_ready,
    output logic          push,
    output spu_op_e       push_op,
    output logic [AW-1:0] push_idx,
    output logic [DW-1:0] push_opnd,
    output logic          err
);
    localparam logic [DW-1:0] LIMIT_MAX = DW'(DEPTH);

    typedef struct packed {
        logic [DW-1:0] opnd;
        spu_op_e       mode;
        logic [DW-1:0] limit;
        logic          err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic fire;

    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.err = 1'b0;
        fire     = wr_valid && !fifo_full;
        push     = 1'b0;
        if (fire) begin
            unique case (wr_addr)
                REG_OPND:  cfg_d.opnd = wr_data;
                REG_MODE:  cfg_d.mode = spu_op_e'(wr_data[0]);
                REG_LIMIT: cfg_d.limit = (wr_data > LIMIT_MAX) ? LIMIT_MAX : wr_data;
                default: begin
                    if (wr_data < cfg_q.limit) push = 1'b1;
                    else                       cfg_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.opnd  <= '0;
            cfg_q.mode  <= OP_ADD;
            cfg_q.limit <= LIMIT_MAX;
            cfg_q.err   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign wr_ready  = !fifo_full;
    assign push_op   = cfg_q.mode;
    assign push_idx  = wr_data[AW-1:0];
    assign push_opnd = cfg_q.opnd;
    assign err       = cfg_q.err;

    assert_err_after_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.err |-> $past(wr_valid && wr_ready && wr_addr == REG_INDEX));

    assert_limit_clamped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.limit <= LIMIT_MAX);
endmodule

// File: rtl/spu_upd_fifo.sv
module spu_upd_fifo #(
    parameter int W     = 39,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = bump(ptr_q.wp);
        if (pop)  ptr_d.rp = bump(ptr_q.rp);
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q.wp] <= din;
    end

    assign dout  = mem[ptr_q.rp];
    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CW'(DEPTH));

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/spu_sram.sv
module spu_sram #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (re) rdata_q <= mem[raddr];
            if (we) mem[waddr] <= wdata;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/spu_rmw_pipe.sv
module spu_rmw_pipe
    import spu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  spu_op_e       ent_op,
    input  logic [AW-1:0] ent_idx,
    input  logic [DW-1:0] ent_opnd,
    input  logic          ext_rd,
    input  logic [DW-1:0] sram_rdata,
    output logic          pop,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    typedef struct packed {
        logic          vld;
        spu_op_e       op;
        logic [AW-1:0] idx;
        logic [DW-1:0] opnd;
        logic          fwd;
        logic [DW-1:0] fwd_val;
    } stage_t;

    stage_t st_d, st_q;
    logic [DW-1:0] base;
    logic [DW-1:0] result;

    always_comb begin
        base   = st_q.fwd ? st_q.fwd_val : sram_rdata;
        result = (st_q.op == OP_ADD) ? base + st_q.opnd
               : ((st_q.opnd < base) ? st_q.opnd : base);
        pop    = !fifo_empty && !ext_rd;

        st_d         = st_q;
        st_d.vld     = pop;
        st_d.op      = ent_op;
        st_d.idx     = ent_idx;
        st_d.opnd    = ent_opnd;
        st_d.fwd     = pop && st_q.vld && (st_q.idx == ent_idx);
        st_d.fwd_val = result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_ADD;
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = st_q.vld;
    assign waddr = st_q.idx;
    assign wdata = result;

    assert_min_not_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && st_q.op == OP_MIN) |-> (wdata <= st_q.opnd && wdata <= base));

    assert_fwd_same_vertex_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.fwd) |-> ($past(we) && $past(waddr) == st_q.idx));
endmodule

// File: rtl/spu_atomic_engine.sv
module spu_atomic_engine
    import spu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DEPTH  = 64,
    parameter int QDEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int EW    = 1 + AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          err_o
);
    logic          push, pop, full, empty;
    spu_op_e       push_op;
    logic [AW-1:0] push_idx;
    logic [DW-1:0] push_opnd;
    logic [EW-1:0] q_in, q_out;
    spu_op_e       ent_op;
    logic [AW-1:0] ent_idx;
    logic [DW-1:0] ent_opnd;
    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata, sram_rdata;

    spu_cfg_regs #(.DW(DW), .DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .fifo_full(full), .wr_ready(wr_ready), .push(push),
        .push_op(push_op), .push_idx(push_idx), .push_opnd(push_opnd), .err(err_o)
    );

    assign q_in     = {push_op, push_idx, push_opnd};
    assign ent_op   = spu_op_e'(q_out[EW-1]);
    assign ent_idx  = q_out[DW +: AW];
    assign ent_opnd = q_out[DW-1:0];

    spu_upd_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(q_in), .pop(pop),
        .dout(q_out), .full(full), .empty(empty)
    );

    spu_rmw_pipe #(.DW(DW), .DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .fifo_empty(empty), .ent_op(ent_op),
        .ent_idx(ent_idx), .ent_opnd(ent_opnd), .ext_rd(rd_en),
        .sram_rdata(sram_rdata), .pop(pop), .we(we), .waddr(waddr), .wdata(wdata)
    );

    spu_sram #(.DW(DW), .DEPTH(DEPTH)) u_sram (
        .clk(clk), .rst_n(rst_n), .re(rd_en || pop),
        .raddr(rd_en ? rd_addr : ent_idx), .rdata(sram_rdata),
        .we(we), .waddr(waddr), .wdata(wdata)
    );

    assign rd_data = sram_rdata;

    assert_read_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !we);

    assert_err_no_enqueue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !$past(push));
endmodule

// File: tb/tb_spu_atomic_engine.sv
module tb_spu_atomic_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        err_o;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] model [64];
    logic [31:0] opnd_m = '0;
    logic        mode_m = 1'b0;
    int          limit_m = 64;

    logic [31:0] exp_v [$];
    string       exp_tag [$];
    logic        mon_en = 1'b1;
    logic        rd_issued = 1'b0;

    always #4 clk = ~clk;

    spu_atomic_engine dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare read data one cycle after rd_en was sampled
    always @(posedge clk) rd_issued <= rd_en && mon_en;
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_v.size() == 0) chk(1'b0, "R9 unexpected read", rd_data, '0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_v.pop_front();
                t = exp_tag.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic set_opnd(input logic [31:0] d);
        wr(2'd0, d); opnd_m = d;
    endtask

    task automatic set_mode(input logic m);
        wr(2'd2, {31'd0, m}); mode_m = m;
    endtask

    task automatic set_limit(input int n);
        wr(2'd3, 32'(n)); limit_m = (n > 64) ? 64 : n;
    endtask

    task automatic model_upd(input int i);
        if (i < limit_m) begin
            if (mode_m) model[i] = (opnd_m < model[i]) ? opnd_m : model[i];
            else        model[i] = model[i] + opnd_m;
        end
    endtask

    task automatic upd(input int i);
        wr(2'd1, 32'(i)); model_upd(i);
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 6'(a);
        exp_v.push_back(model[a]); exp_tag.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(err_o == 1'b0, "R1 err_o", 32'(err_o), 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 1);
        rd(0, "R1 entry 0");
        rd(63, "R1 entry 63");
        settle();

        // R2 R3 add mode, wrap-around
        set_opnd(32'd10); upd(3);
        set_opnd(32'hFFFF_FFFF); upd(5); upd(5);
        settle();
        rd(3, "R2 add via index write");
        rd(5, "R3 wrap add");
        settle();

        // R4 unsigned min
        set_mode(1'b1);
        set_opnd(32'd20); upd(3);
        set_opnd(32'h8000_0000); upd(5);
        settle();
        rd(3, "R4 min keeps stored");
        rd(5, "R4 min unsigned operand");
        settle();

        // R5 mode captured at acceptance
        set_opnd(32'd5); upd(3);
        set_mode(1'b0);
        settle();
        rd(3, "R5 mode captured");
        settle();

        // R8 back-to-back same vertex
        set_opnd(32'd7); upd(4); upd(4); upd(4);
        upd(7); upd(8); upd(7);
        settle();
        rd(4, "R8 three updates same vertex");
        rd(7, "R8 interleaved vertex");
        rd(8, "R8 interleaved other");
        settle();

        // R6 R9 back-pressure while reads hold the SRAM port
        mon_en = 1'b0;
        @(negedge clk); rd_en = 1'b1; rd_addr = 6'd63;
        set_opnd(32'd9);
        for (int i = 20; i < 28; i++) upd(i);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R6 full after 8", 32'(wr_ready), 0);
        wr_valid = 1'b1; wr_addr = 2'd1; wr_data = 32'd28;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(wr_ready == 1'b0, "R6 R9 stall holds", 32'(wr_ready), 0);
        end
        rd_en = 1'b0;
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        model_upd(28);
        repeat (14) @(negedge clk);
        mon_en = 1'b1;
        for (int i = 20; i < 29; i++) rd(i, "R6 queued update applied");
        settle();

        // R7 out of range
        set_limit(16);
        set_opnd(32'd3);
        upd(40);
        @(negedge clk);
        chk(err_o == 1'b1, "R7 err pulse", 32'(err_o), 1);
        @(negedge clk);
        chk(err_o == 1'b0, "R7 err one cycle", 32'(err_o), 0);
        upd(15);
        settle();
        rd(40, "R7 no write");
        rd(15, "R7 in range");
        settle();

        // R10 clamp
        set_limit(1000);
        upd(63);
        upd(64);
        @(negedge clk);
        chk(err_o == 1'b1, "R10 index 64 rejected", 32'(err_o), 1);
        settle();
        rd(63, "R10 top entry in range");
        rd(0, "R10 entry 0 untouched");
        settle();

        chk(exp_v.size() == 0, "R9 reads all returned", 32'(exp_v.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule